// File: doc/BRIEF.md
# Synchronous ROM Command Front End

This block sits at the pin side of a synchronous read-only memory. It samples the control strobes, the clock enable and a shared 13-bit address bus on every rising clock edge. It turns each sampled set into one of a small set of commands: deselect, no-operation, row open, column read or mode program. It keeps the mode register that the later burst and latency logic reads. It also captures the row and column halves of the address and joins them into one word address for each read it accepts.

The clock enable freezes the block. A low level sampled on one edge makes the block ignore the next edge. It then reports either power-down (no row open) or clock suspend (row open). A width pin, sampled with every column read, selects how the column bits fill the word address. A mode program starts a fixed lockout during which every command is dropped. A mode program that carries a reserved code, or that arrives once a row has been opened, is refused and flagged.

Top module: `srom_cmd_front`

## Requirements
- R1: After reset the mode fields show the default code (row latency 1, column latency 4, sequential, burst 4). The read pulse, busy, error, power-down, suspend and row-open outputs are all low.
- R2: With chip select, row strobe, column strobe and mode strobe all low, the code on addr[6:0] is stored, and the mode outputs show it from the next cycle. The fields decode as follows. addr[1:0]: 01 gives burst 4 and 10 gives burst 8. addr[2]: 1 gives interleaved order and 0 gives sequential order. addr[5:3]: 010, 011, 100 and 101 give column latency 3, 4, 5 and 6. addr[6]: 0 gives row latency 1 and 1 gives row latency 2.
- R3: A mode program whose burst code or latency code is any other value leaves the register unchanged and raises mode_err for one cycle.
- R4: After an accepted mode program, mode_busy is high for 3 cycles. Every command sampled on those 3 edges is ignored.
- R5: A mode program that arrives after a row has been opened is refused. The register keeps its value and mode_err pulses.
- R6: A row open (chip select low, row strobe low, column and mode strobes high) stores addr[12:0] as the row and sets row_open. When several row opens come back to back, the last one sets the row.
- R7: A read (chip select low, column strobe low, row and mode strobes high) with a row open gives a one-cycle rd_req in the next cycle. A read with no row open gives no rd_req.
- R8: With the width pin high, rd_addr = {0, row, addr[7:0]}, rd_wide = 1, and addr[8] has no effect. With the width pin low, rd_addr = {row, addr[8:0]} and rd_wide = 0.
- R9: Chip select high makes all other inputs ignored. With all three strobes high, the block does nothing.
- R10: Clock enable low on an edge makes the next edge ignored and holds the state. During that time pwr_down is high if no row is open, and clk_susp is high if a row is open.
- R11: The first edge at which clock enable is high again is still ignored. Commands are accepted from the edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| mode_n | input | 1 | Mode-program strobe, active low |
| addr | input | 13 | Shared row / column / mode-code bus |
| wide_pin | input | 1 | Width select sampled at read: 1 = 32-bit, 0 = 16-bit |
| rd_req | output | 1 | One-cycle pulse for each accepted read |
| rd_addr | output | 22 | Word address of the last accepted read |
| rd_wide | output | 1 | Width chosen for the last accepted read |
| row_open | output | 1 | A row has been opened |
| mode_busy | output | 1 | Lockout after a mode program |
| mode_err | output | 1 | One-cycle pulse for a refused mode program |
| pwr_down | output | 1 | Frozen with no row open |
| clk_susp | output | 1 | Frozen with a row open |
| burst8 | output | 1 | Burst length 8 when high, 4 when low |
| burst_ilv | output | 1 | Interleaved burst order |
| cas_lat | output | 3 | Column latency in cycles (3 to 6) |
| ras_lat | output | 2 | Row latency in cycles (1 or 2) |

## Verification
The bench sweeps all 128 mode codes, so every reserved combination is tried. A design that let a reserved code through would show a latency or burst value outside its legal range. The bench drives row opens during each lockout. A lockout that was one cycle short would set row_open too early. It also sends reads while frozen and on the first edge after the clock enable comes back. A design that dropped the extra wait cycle, or that did not freeze, would give a stray rd_req. The read sweep alternates the width pin over varied rows and columns. Swapping the x16 and x32 column packing, or letting column bit 8 leak into a 32-bit address, shows up as a wrong rd_addr.

// File: rtl/srom_cmd_pkg.sv
// Package: shared command and mode types for the synchronous ROM front end.
// Assumes the mode code occupies address bits 6..0 in the field order of mode_t.
package srom_cmd_pkg;

    // Decoded command of one sampled edge; CMD_NONE means the edge was dropped.
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_DESEL,
        CMD_NOP,
        CMD_ACT,
        CMD_RD,
        CMD_MRS,
        CMD_OTHER
    } cmd_e;

    // Mode code, most significant field first (bit 6 down to bit 0).
    typedef struct packed {
        logic       ras2;     // row latency 2 when set
        logic [2:0] cl_code;  // column latency code
        logic       ilv;      // interleaved burst order
        logic [1:0] bl_code;  // burst length code
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    // True when neither the burst code nor the latency code is reserved.
    function automatic logic mode_code_ok(mode_t m);
        return ((m.bl_code == 2'b01) || (m.bl_code == 2'b10)) &&
               (m.cl_code >= 3'd2) && (m.cl_code <= 3'd5);
    endfunction

endpackage

// File: rtl/srom_clk_gate.sv
// Module: tracks the clock enable and reports whether the current edge may act.
// Assumes a low enable sampled on one edge freezes the following edge, so the
// first edge with the enable high again is still frozen.
module srom_clk_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic row_open,
    output logic run,
    output logic pwr_down,
    output logic clk_susp
);

    logic cke_q;

    // Registers the enable seen on the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b1;
        else        cke_q <= cke;
    end

    // Splits the frozen state by whether a row is open.
    always_comb begin
        run      = cke_q;
        pwr_down = !cke_q && !row_open;
        clk_susp = !cke_q && row_open;
    end

    AST_FREEZE_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n) !(pwr_down && clk_susp)); // R10
    AST_WAKE_STILL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) (!run && cke) |=> run); // R11

endmodule

// File: rtl/srom_cmd_decode.sv
// Module: turns the sampled strobes into one command per edge.
// Assumes accept already folds in the clock-enable freeze and the mode lockout.
module srom_cmd_decode
    import srom_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic mode_n,
    input  logic accept,
    output cmd_e cmd
);

    // Maps the strobe pattern onto a command; dropped edges give CMD_NONE.
    always_comb begin
        if (!accept) begin
            cmd = CMD_NONE;
        end else if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            unique case ({ras_n, cas_n, mode_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b000:  cmd = CMD_MRS;
                default: cmd = CMD_OTHER;
            endcase
        end
    end

endmodule

// File: rtl/srom_mode_reg.sv
// Module: holds the mode register, refuses bad programs and runs the lockout.
// Assumes cmd is CMD_NONE on frozen or locked edges, and run is low when frozen.
module srom_mode_reg
    import srom_cmd_pkg::*;
#(
    parameter logic [6:0] MODE_DEFAULT = 7'b0011001,
    parameter int         MRS_LOCK     = 3,
    localparam int        LOCK_W       = $clog2(MRS_LOCK + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  cmd_e              cmd,
    input  logic [MODE_W-1:0] code,
    input  logic              row_open,
    output mode_t             mode,
    output logic              busy,
    output logic              err
);

    mode_t             mode_q;
    mode_t             code_m;
    logic [LOCK_W-1:0] lock_cnt;
    logic              prog_ok;
    logic              prog_bad;

    // Classifies a mode program as accepted or refused.
    always_comb begin
        code_m   = mode_t'(code);
        prog_ok  = (cmd == CMD_MRS) && !row_open && mode_code_ok(code_m);
        prog_bad = (cmd == CMD_MRS) && !prog_ok;
    end

    // Loads the register on an accepted program.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= mode_t'(MODE_DEFAULT);
        else if (prog_ok) mode_q <= code_m;
    end

    // Counts down the lockout after a program; holds while frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)                      lock_cnt <= '0;
        else if (prog_ok)                lock_cnt <= LOCK_W'(MRS_LOCK);
        else if (run && lock_cnt != '0)  lock_cnt <= lock_cnt - 1'b1;
    end

    // Pulses the error flag for one cycle on a refused program.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= prog_bad;
    end

    // Drives the outputs from state.
    always_comb begin
        mode = mode_q;
        busy = (lock_cnt != '0);
    end

    AST_MODE_ALWAYS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) mode_code_ok(mode_q)); // R3
    AST_LOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n) lock_cnt <= LOCK_W'(MRS_LOCK)); // R4
    AST_LOCK_STARTS: assert property (@(posedge clk) disable iff (!rst_n) prog_ok |=> busy); // R4
    AST_OPEN_ROW_REFUSES: assert property (@(posedge clk) disable iff (!rst_n) (cmd == CMD_MRS && row_open) |=> (err && $stable(mode_q))); // R5
    AST_FROZEN_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !run |=> $stable(mode_q)); // R10

endmodule

// File: rtl/srom_addr_latch.sv
// Module: captures the row and column halves and forms the word address.
// Assumes the column for 16-bit access uses one more bit than for 32-bit
// access, and that this bit fits on the shared address bus.
module srom_addr_latch
    import srom_cmd_pkg::*;
#(
    parameter  int ROW_W   = 13,
    parameter  int COL_W   = 8,
    localparam int WADDR_W = ROW_W + COL_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_e               cmd,
    input  logic [ROW_W-1:0]   addr,
    input  logic               wide_pin,
    output logic               row_open,
    output logic               rd_req,
    output logic [WADDR_W-1:0] rd_addr,
    output logic               rd_wide
);

    logic [ROW_W-1:0]   row_q;
    logic [WADDR_W-1:0] addr_next;
    logic               rd_take;

    // Stores the row of the latest row open; later opens replace earlier ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            row_open <= 1'b0;
        end else if (cmd == CMD_ACT) begin
            row_q    <= addr;
            row_open <= 1'b1;
        end
    end

    // Packs row and column by the width sampled with the read.
    generate
        if (COL_W + 1 <= ROW_W) begin : g_pack
            always_comb begin
                if (wide_pin) addr_next = {1'b0, row_q, addr[COL_W-1:0]};
                else          addr_next = {row_q, addr[COL_W:0]};
            end
        end else begin : g_pack_narrow
            always_comb begin
                addr_next = '0;
            end
        end
    endgenerate

    // A read is taken only when a row is open.
    always_comb rd_take = (cmd == CMD_RD) && row_open;

    // Issues the one-cycle read request and holds the last address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req  <= 1'b0;
            rd_addr <= '0;
            rd_wide <= 1'b0;
        end else begin
            rd_req <= rd_take;
            if (rd_take) begin
                rd_addr <= addr_next;
                rd_wide <= wide_pin;
            end
        end
    end

    AST_READ_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n) rd_req |-> row_open); // R7
    AST_WIDE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (rd_req && rd_wide) |-> !rd_addr[WADDR_W-1]); // R8
    AST_ROW_STICKS: assert property (@(posedge clk) disable iff (!rst_n) row_open |=> row_open); // R6

endmodule

// File: rtl/srom_cmd_front.sv
// Module: top of the synchronous ROM command front end.
// Samples strobes, clock enable and the shared address bus; exposes decoded
// reads, the joined word address and the current mode fields.
// Assumes the storage array and burst sequencing are handled downstream.
module srom_cmd_front
    import srom_cmd_pkg::*;
#(
    parameter  int         ROW_W        = 13,
    parameter  int         COL_W        = 8,
    parameter  int         MRS_LOCK     = 3,
    parameter  logic [6:0] MODE_DEFAULT = 7'b0011001,
    localparam int         WADDR_W      = ROW_W + COL_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cke,
    input  logic               cs_n,
    input  logic               ras_n,
    input  logic               cas_n,
    input  logic               mode_n,
    input  logic [ROW_W-1:0]   addr,
    input  logic               wide_pin,
    output logic               rd_req,
    output logic [WADDR_W-1:0] rd_addr,
    output logic               rd_wide,
    output logic               row_open,
    output logic               mode_busy,
    output logic               mode_err,
    output logic               pwr_down,
    output logic               clk_susp,
    output logic               burst8,
    output logic               burst_ilv,
    output logic [2:0]         cas_lat,
    output logic [1:0]         ras_lat
);

    logic  run;
    logic  accept;
    cmd_e  cmd;
    mode_t mode;

    srom_clk_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .row_open (row_open),
        .run      (run),
        .pwr_down (pwr_down),
        .clk_susp (clk_susp)
    );

    // An edge acts only when not frozen and not locked out.
    always_comb accept = run && !mode_busy;

    srom_cmd_decode u_dec (
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .mode_n (mode_n),
        .accept (accept),
        .cmd    (cmd)
    );

    srom_mode_reg #(
        .MODE_DEFAULT (MODE_DEFAULT),
        .MRS_LOCK     (MRS_LOCK)
    ) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cmd      (cmd),
        .code     (addr[MODE_W-1:0]),
        .row_open (row_open),
        .mode     (mode),
        .busy     (mode_busy),
        .err      (mode_err)
    );

    srom_addr_latch #(
        .ROW_W (ROW_W),
        .COL_W (COL_W)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .addr     (addr),
        .wide_pin (wide_pin),
        .row_open (row_open),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_wide  (rd_wide)
    );

    // Decodes the stored code into the published mode fields.
    always_comb begin
        burst8    = (mode.bl_code == 2'b10);
        burst_ilv = mode.ilv;
        cas_lat   = mode.cl_code + 3'd1;
        ras_lat   = mode.ras2 ? 2'd2 : 2'd1;
    end

    AST_LOCK_DROPS_READ: assert property (@(posedge clk) disable iff (!rst_n) (mode_busy && !cs_n && ras_n && !cas_n && mode_n) |=> !rd_req); // R4
    AST_FROZEN_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) (pwr_down || clk_susp) |=> !rd_req); // R10
    AST_DESELECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) cs_n |=> !rd_req); // R9
    AST_LAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (cas_lat >= 3'd3 && cas_lat <= 3'd6)); // R2

endmodule

// File: tb/srom_cmd_front_tb.sv
// Bench: sweeps mode codes, read addresses and clock-enable sequences.
module srom_cmd_front_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic        cs_n = 1'b1;
    logic        ras_n = 1'b1;
    logic        cas_n = 1'b1;
    logic        mode_n = 1'b1;
    logic [12:0] addr = '0;
    logic        wide_pin = 1'b0;
    logic        rd_req;
    logic [21:0] rd_addr;
    logic        rd_wide;
    logic        row_open;
    logic        mode_busy;
    logic        mode_err;
    logic        pwr_down;
    logic        clk_susp;
    logic        burst8;
    logic        burst_ilv;
    logic [2:0]  cas_lat;
    logic [1:0]  ras_lat;

    int errors = 0;
    int checks = 0;
    logic [6:0] exp_code;

    always #5 clk = ~clk;

    srom_cmd_front dut_i (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n), .ras_n (ras_n),
        .cas_n (cas_n), .mode_n (mode_n), .addr (addr), .wide_pin (wide_pin),
        .rd_req (rd_req), .rd_addr (rd_addr), .rd_wide (rd_wide),
        .row_open (row_open), .mode_busy (mode_busy), .mode_err (mode_err),
        .pwr_down (pwr_down), .clk_susp (clk_susp), .burst8 (burst8),
        .burst_ilv (burst_ilv), .cas_lat (cas_lat), .ras_lat (ras_lat)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Applies one command for one edge, then waits just past that edge.
    task automatic drive(input logic c, input logic r, input logic k, input logic m,
                         input logic [12:0] a, input logic w);
        cs_n = c; ras_n = r; cas_n = k; mode_n = m; addr = a; wide_pin = w;
        @(posedge clk);
        #1;
    endtask

    task automatic nop();     drive(1'b0, 1'b1, 1'b1, 1'b1, 13'h0, 1'b0); endtask
    task automatic act_row(input logic [12:0] r); drive(1'b0, 1'b0, 1'b1, 1'b1, r, 1'b0); endtask
    task automatic rd(input logic [12:0] c, input logic w); drive(1'b0, 1'b1, 1'b0, 1'b1, c, w); endtask
    task automatic prog(input logic [6:0] code); drive(1'b0, 1'b0, 1'b0, 1'b0, {6'b0, code}, 1'b0); endtask

    function automatic logic code_ok(input logic [6:0] c);
        return ((c[1:0] == 2'b01) || (c[1:0] == 2'b10)) && (c[5:3] >= 3'd2) && (c[5:3] <= 3'd5);
    endfunction

    // Expected {ras_lat, cas_lat, ilv, burst8} from a code, by arithmetic.
    function automatic logic [6:0] fields(input logic [6:0] c);
        return {(c[6] ? 2'd2 : 2'd1), 3'(c[5:3] + 3'd1), c[2], (c[1:0] == 2'b10)};
    endfunction

    function automatic logic [21:0] word_addr(input logic [12:0] r, input logic [12:0] c, input logic w);
        return w ? {1'b0, r, c[7:0]} : {r, c[8:0]};
    endfunction

    task automatic check_mode(input string what);
        check({25'b0, ras_lat, cas_lat, burst_ilv, burst8}, {25'b0, fields(exp_code)}, what);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        exp_code = 7'b0011001;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        nop();
        // R1 reset state
        check_mode("R1 default mode");
        check({rd_req, mode_busy, mode_err, pwr_down, clk_susp, row_open}, 0, "R1 outputs low");

        // R9 deselect ignores a row open and a mode program
        drive(1'b1, 1'b0, 1'b1, 1'b1, 13'h1abc, 1'b0);
        check(row_open, 0, "R9 deselect row");
        drive(1'b1, 1'b0, 1'b0, 1'b0, 13'h006e, 1'b0);
        check({mode_busy, mode_err}, 0, "R9 deselect mode busy/err");
        check_mode("R9 deselect mode kept");
        nop();
        check({rd_req, row_open, mode_busy, mode_err}, 0, "R9 nop idle");

        // R7 read without an open row
        rd(13'h055, 1'b1);
        check(rd_req, 0, "R7 read with no row");

        // R2 R3 R4 sweep every mode code, probing the lockout with row opens
        for (int i = 0; i < 128; i++) begin
            logic [6:0] c;
            c = 7'(i);
            prog(c);
            if (code_ok(c)) exp_code = c;
            check(mode_err, !code_ok(c), "R3 error flag");
            check_mode("R2 mode fields");
            if (code_ok(c)) begin
                check(mode_busy, 1, "R4 busy start");
                for (int k = 0; k < 3; k++) begin
                    act_row(13'h1fff);
                    check(row_open, 0, "R4 command dropped in lockout");
                    check(mode_busy, (k < 2), "R4 busy length");
                end
            end
        end

        // R10 R11 power-down freeze and wake-up
        cke = 1'b0;
        nop();
        check(pwr_down, 1, "R10 power down");
        check(clk_susp, 0, "R10 not suspend");
        prog(7'b0010001);
        check_mode("R10 frozen program ignored");
        check(mode_busy, 0, "R10 frozen no lockout");
        act_row(13'h0123);
        check(row_open, 0, "R10 frozen row ignored");
        cke = 1'b1;
        act_row(13'h0123);
        check(row_open, 0, "R11 wake edge ignored");
        check(pwr_down, 0, "R11 power down left");

        // R6 last row open wins
        act_row(13'h0aaa);
        check(row_open, 1, "R6 row open");
        act_row(13'h1555);
        rd(13'h1f0, 1'b0);
        check(rd_req, 1, "R7 read issued");
        check(rd_addr, word_addr(13'h1555, 13'h1f0, 1'b0), "R6 last row used");

        // R5 program refused with a row open
        prog(7'b0010001);
        check(mode_err, 1, "R5 error");
        check_mode("R5 mode kept");
        check(mode_busy, 0, "R5 no lockout");

        // R7 R8 read sweep over rows, columns and widths
        for (int i = 0; i < 64; i++) begin
            logic [12:0] r;
            logic [12:0] c;
            logic w;
            r = 13'(i * 197 + 5);
            c = 13'(i * 37 + 3);
            w = i[0];
            act_row(r);
            rd(c, w);
            check(rd_req, 1, "R7 read pulse");
            check(rd_addr, word_addr(r, c, w), "R8 word address");
            check(rd_wide, w, "R8 width echo");
            nop();
            check(rd_req, 0, "R7 pulse one cycle");
        end
        // R8 column bit 8 ignored at 32-bit width
        act_row(13'h0f0f);
        rd(13'h100, 1'b1);
        check(rd_addr, {1'b0, 13'h0f0f, 8'h00}, "R8 bit 8 ignored wide");

        // R10 R11 clock suspend with a row open
        cke = 1'b0;
        nop();
        check(clk_susp, 1, "R10 clock suspend");
        check(pwr_down, 0, "R10 not power down");
        rd(13'h077, 1'b0);
        check(rd_req, 0, "R10 suspended read dropped");
        cke = 1'b1;
        rd(13'h077, 1'b0);
        check(rd_req, 0, "R11 wake read dropped");
        rd(13'h077, 1'b0);
        check(rd_req, 1, "R11 read after wake");
        check(rd_addr, word_addr(13'h0f0f, 13'h077, 1'b0), "R11 address after wake");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule